// File: doc/BRIEF.md
# Multicycle Processor Sequencing Controller

This block sequences a 32-bit load/store processor that executes every instruction over several clock cycles and reuses one memory, one ALU and one register file across those cycles. Its only data input is the 6-bit opcode field of the instruction register. From that opcode it walks through fetch, decode, execute, memory-access and write-back steps, and in each step it drives a fixed set of datapath controls: PC update enables, the memory address source, memory read and write strobes, the instruction-register load, register-file write controls, ALU operand selects, the ALU mode and the next-PC source.

The controller is a Moore machine with ten numbered steps. Every output depends only on the current step. The opcode is consulted twice, once in decode to pick the instruction class and once in the address-calculation step to split loads from stores. Any select that a step does not use is driven 0, so the whole output vector is defined in every step. The current step number is brought out on `step_code` so that the surrounding datapath and the bench can trace the sequence.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: A synchronous `rst` high at a rising edge places the controller in step 0 (fetch). `step_code` reads 0 and the outputs show the fetch vector while `rst` stays high.
- R2: Step 0 (fetch) asserts `pc_wr_en`, `mem_rd` and `ir_load`, with `addr_sel_data`=0, `alu_a_sel`=0, `alu_b_sel`=01, `alu_mode`=00 and `pc_next_sel`=00. It always moves to step 1.
- R3: Step 1 (decode) asserts only `alu_b_sel`=11, and every other output is 0. It moves on by opcode: 6'b100011 (load) or 6'b101011 (store) to step 2, 6'b000000 (register ALU op) to step 6, 6'b000100 (branch-if-equal) to step 8, and 6'b000010 (jump) to step 9.
- R4: Step 2 (address) drives `alu_a_sel`=1 and `alu_b_sel`=10, and every other output is 0. It goes to step 3 for a load opcode, to step 5 for a store opcode, and to step 0 for any other opcode.
- R5: Step 3 (load read) asserts `mem_rd` with `addr_sel_data`=1 and goes to step 4.
- R6: Step 4 (load write-back) asserts `rf_wr` with `wb_sel_mem`=1 and `dst_sel_rd`=0, then goes to step 0.
- R7: Step 5 (store) asserts `mem_wr` with `addr_sel_data`=1, then goes to step 0.
- R8: Step 6 (ALU execute) drives `alu_a_sel`=1, `alu_b_sel`=00 and `alu_mode`=10, then goes to step 7. Step 7 asserts `rf_wr` with `dst_sel_rd`=1 and `wb_sel_mem`=0, then goes to step 0.
- R9: Step 8 (branch) asserts `pc_wr_cond` with `alu_a_sel`=1, `alu_b_sel`=00, `alu_mode`=01 and `pc_next_sel`=01, then goes to step 0.
- R10: Step 9 (jump) asserts `pc_wr_en` with `pc_next_sel`=10, then goes to step 0.
- R11: An opcode outside the five listed in R3, seen in step 1, sends the controller straight back to step 0 without passing through any step that writes memory or the register file.
- R12: `mem_rd` and `mem_wr` are never high together, and `rf_wr` is never high together with `mem_wr`.
- R13: The outputs depend on the current step only. A change of `opcode` within a cycle leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the held instruction |
| step_code | output | 4 | Current step number, 0 to 9 |
| pc_wr_en | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write qualified by the ALU zero flag |
| addr_sel_data | output | 1 | Memory address source: 0 = PC, 1 = ALU result register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_load | output | 1 | Instruction register load |
| dst_sel_rd | output | 1 | Register destination: 0 = rt field, 1 = rd field |
| wb_sel_mem | output | 1 | Write-back data: 0 = ALU result, 1 = memory data register |
| rf_wr | output | 1 | Register-file write enable |
| alu_a_sel | output | 1 | ALU operand A: 0 = PC, 1 = register A |
| alu_b_sel | output | 2 | ALU operand B: 00 = register B, 01 = constant 4, 10 = extended immediate, 11 = shifted extended immediate |
| alu_mode | output | 2 | ALU mode: 00 add, 01 subtract, 10 function-field driven |
| pc_next_sel | output | 2 | Next-PC source: 00 ALU, 01 ALU result register, 10 jump target |

## Verification
Two things meet in the same cycle here. The fetch step starts a memory read, loads the instruction register and writes the PC all at once. In the decode and address steps, the opcode that is being dispatched on may change while the step's own outputs are being driven. The bench provokes this by changing the opcode at random in the middle of instructions, and inside a load-read step it flips the opcode and samples again before the next edge. A bench-side step model judges both the full output vector and the next step number in every cycle.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  localparam int OP_W   = 6;
  localparam int STEP_W = 4;

  typedef enum logic [STEP_W-1:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_ADDR   = 4'd2,
    ST_LDRD   = 4'd3,
    ST_LDWB   = 4'd4,
    ST_STWR   = 4'd5,
    ST_ALUEX  = 4'd6,
    ST_ALUWB  = 4'd7,
    ST_BRANCH = 4'd8,
    ST_JUMP   = 4'd9
  } step_e;

  localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OPC_JUMP  = 6'b000010;

  typedef struct packed {
    logic       pc_wr_en;
    logic       pc_wr_cond;
    logic       addr_sel_data;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_load;
    logic       dst_sel_rd;
    logic       wb_sel_mem;
    logic       rf_wr;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic [1:0] alu_mode;
    logic [1:0] pc_next_sel;
  } ctrl_t;

  localparam ctrl_t CTRL_IDLE = '0;

endpackage

// File: rtl/mc_ctrl_next.sv
module mc_ctrl_next
  import mc_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  step_e           cur,
  input  logic [OP_W-1:0] opcode,
  output step_e           nxt
);

  function automatic step_e decode_target(input logic [OP_W-1:0] op);
    case (op)
      OPC_LOAD, OPC_STORE: decode_target = ST_ADDR;
      OPC_RTYPE:           decode_target = ST_ALUEX;
      OPC_BEQ:             decode_target = ST_BRANCH;
      OPC_JUMP:            decode_target = ST_JUMP;
      default:             decode_target = ST_FETCH;
    endcase
  endfunction

  function automatic step_e addr_target(input logic [OP_W-1:0] op);
    if (op == OPC_LOAD)       addr_target = ST_LDRD;
    else if (op == OPC_STORE) addr_target = ST_STWR;
    else                      addr_target = ST_FETCH;
  endfunction

  logic op_known;
  assign op_known = (opcode == OPC_LOAD) || (opcode == OPC_STORE) ||
                    (opcode == OPC_RTYPE) || (opcode == OPC_BEQ) ||
                    (opcode == OPC_JUMP);

  always_comb begin
    case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: nxt = decode_target(opcode);
      ST_ADDR:   nxt = addr_target(opcode);
      ST_LDRD:   nxt = ST_LDWB;
      ST_ALUEX:  nxt = ST_ALUWB;
      default:   nxt = ST_FETCH;
    endcase
  end

  p_fetch_to_decode_r2: assert property (@(posedge clk) disable iff (rst)
    cur == ST_FETCH |=> cur == ST_DECODE);
  p_rtype_dispatch_r3: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_DECODE && opcode == OPC_RTYPE) |=> cur == ST_ALUEX);
  p_store_split_r4: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_ADDR && opcode == OPC_STORE) |=> cur == ST_STWR);
  p_load_chain_r5: assert property (@(posedge clk) disable iff (rst)
    cur == ST_LDRD |=> cur == ST_LDWB);
  p_ldwb_return_r6: assert property (@(posedge clk) disable iff (rst)
    cur == ST_LDWB |=> cur == ST_FETCH);
  p_alu_chain_r8: assert property (@(posedge clk) disable iff (rst)
    cur == ST_ALUEX |=> cur == ST_ALUWB);
  p_unknown_op_r11: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_DECODE && !op_known) |=> cur == ST_FETCH);

endmodule

// File: rtl/mc_ctrl_state_reg.sv
module mc_ctrl_state_reg
  import mc_ctrl_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  step_e nxt,
  output step_e cur
);

  always_ff @(posedge clk) begin
    if (rst) cur <= ST_FETCH;
    else     cur <= nxt;
  end

endmodule

// File: rtl/mc_ctrl_out.sv
module mc_ctrl_out
  import mc_ctrl_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  step_e cur,
  output ctrl_t ctl
);

  function automatic ctrl_t step_vector(input step_e s);
    ctrl_t c;
    c = CTRL_IDLE;
    case (s)
      ST_FETCH: begin
        c.pc_wr_en = 1'b1; c.mem_rd = 1'b1; c.ir_load = 1'b1;
        c.alu_b_sel = 2'b01;
      end
      ST_DECODE: c.alu_b_sel = 2'b11;
      ST_ADDR: begin
        c.alu_a_sel = 1'b1; c.alu_b_sel = 2'b10;
      end
      ST_LDRD: begin
        c.mem_rd = 1'b1; c.addr_sel_data = 1'b1;
      end
      ST_LDWB: begin
        c.rf_wr = 1'b1; c.wb_sel_mem = 1'b1;
      end
      ST_STWR: begin
        c.mem_wr = 1'b1; c.addr_sel_data = 1'b1;
      end
      ST_ALUEX: begin
        c.alu_a_sel = 1'b1; c.alu_mode = 2'b10;
      end
      ST_ALUWB: begin
        c.rf_wr = 1'b1; c.dst_sel_rd = 1'b1;
      end
      ST_BRANCH: begin
        c.pc_wr_cond = 1'b1; c.alu_a_sel = 1'b1;
        c.alu_mode = 2'b01; c.pc_next_sel = 2'b01;
      end
      ST_JUMP: begin
        c.pc_wr_en = 1'b1; c.pc_next_sel = 2'b10;
      end
      default: c = CTRL_IDLE;
    endcase
    return c;
  endfunction

  assign ctl = step_vector(cur);

  p_no_rd_wr_r12: assert property (@(posedge clk) disable iff (rst)
    !(ctl.mem_rd && ctl.mem_wr));
  p_no_rf_mem_wr_r12: assert property (@(posedge clk) disable iff (rst)
    !(ctl.rf_wr && ctl.mem_wr));
  p_decode_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl.ir_load) |=> !ctl.ir_load && !ctl.pc_wr_en);
  p_store_return_r7: assert property (@(posedge clk) disable iff (rst)
    ctl.mem_wr |=> ctl.ir_load);

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mc_ctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [5:0]  opcode,
  output logic [3:0]  step_code,
  output logic        pc_wr_en,
  output logic        pc_wr_cond,
  output logic        addr_sel_data,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic        ir_load,
  output logic        dst_sel_rd,
  output logic        wb_sel_mem,
  output logic        rf_wr,
  output logic        alu_a_sel,
  output logic [1:0]  alu_b_sel,
  output logic [1:0]  alu_mode,
  output logic [1:0]  pc_next_sel
);

  step_e cur_step;
  step_e nxt_step;
  ctrl_t ctl;

  mc_ctrl_next u_next (
    .clk(clk), .rst(rst), .cur(cur_step), .opcode(opcode), .nxt(nxt_step)
  );

  mc_ctrl_state_reg u_sreg (
    .clk(clk), .rst(rst), .nxt(nxt_step), .cur(cur_step)
  );

  mc_ctrl_out u_out (
    .clk(clk), .rst(rst), .cur(cur_step), .ctl(ctl)
  );

  assign step_code     = cur_step;
  assign pc_wr_en      = ctl.pc_wr_en;
  assign pc_wr_cond    = ctl.pc_wr_cond;
  assign addr_sel_data = ctl.addr_sel_data;
  assign mem_rd        = ctl.mem_rd;
  assign mem_wr        = ctl.mem_wr;
  assign ir_load       = ctl.ir_load;
  assign dst_sel_rd    = ctl.dst_sel_rd;
  assign wb_sel_mem    = ctl.wb_sel_mem;
  assign rf_wr         = ctl.rf_wr;
  assign alu_a_sel     = ctl.alu_a_sel;
  assign alu_b_sel     = ctl.alu_b_sel;
  assign alu_mode      = ctl.alu_mode;
  assign pc_next_sel   = ctl.pc_next_sel;

  p_reset_fetch_r1: assert property (@(posedge clk)
    rst |=> step_code == 4'd0);
  p_jump_return_r10: assert property (@(posedge clk) disable iff (rst)
    (step_code == 4'd9) |=> (step_code == 4'd0));
  p_branch_return_r9: assert property (@(posedge clk) disable iff (rst)
    pc_wr_cond |=> ir_load);

endmodule

// File: tb/test_mc_ctrl_fsm.sv
module test_mc_ctrl_fsm;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic [3:0] step_code;
  logic pc_wr_en, pc_wr_cond, addr_sel_data, mem_rd, mem_wr, ir_load;
  logic dst_sel_rd, wb_sel_mem, rf_wr, alu_a_sel;
  logic [1:0] alu_b_sel, alu_mode, pc_next_sel;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mc_ctrl_fsm i_mc_ctrl_fsm (
    .clk(clk), .rst(rst), .opcode(opcode), .step_code(step_code),
    .pc_wr_en(pc_wr_en), .pc_wr_cond(pc_wr_cond), .addr_sel_data(addr_sel_data),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_load(ir_load), .dst_sel_rd(dst_sel_rd),
    .wb_sel_mem(wb_sel_mem), .rf_wr(rf_wr), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .alu_mode(alu_mode), .pc_next_sel(pc_next_sel)
  );

  // vector order: pcw, cond, addr, rd, wr, ir, dst, wb, rf, a, b[2], mode[2], src[2]
  function automatic logic [15:0] model_vec(input int s);
    case (s)
      0: model_vec = {1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'b01,2'b00,2'b00};
      1: model_vec = {10'b0, 2'b11, 2'b00, 2'b00};
      2: model_vec = {9'b0, 1'b1, 2'b10, 2'b00, 2'b00};
      3: model_vec = {2'b00, 1'b1, 1'b1, 12'b0};
      4: model_vec = {7'b0, 1'b1, 1'b1, 7'b0};
      5: model_vec = {2'b00, 1'b1, 1'b0, 1'b1, 11'b0};
      6: model_vec = {9'b0, 1'b1, 2'b00, 2'b10, 2'b00};
      7: model_vec = {6'b0, 1'b1, 1'b0, 1'b1, 7'b0};
      8: model_vec = {1'b0, 1'b1, 7'b0, 1'b1, 2'b00, 2'b01, 2'b01};
      9: model_vec = {1'b1, 11'b0, 2'b00, 2'b10};
      default: model_vec = 16'hxxxx;
    endcase
  endfunction

  function automatic int model_next(input int s, input logic [5:0] op);
    case (s)
      0: return 1;
      1: begin
        if (op == 6'b100011 || op == 6'b101011) return 2;
        if (op == 6'b000000) return 6;
        if (op == 6'b000100) return 8;
        if (op == 6'b000010) return 9;
        return 0;
      end
      2: begin
        if (op == 6'b100011) return 3;
        if (op == 6'b101011) return 5;
        return 0;
      end
      3: return 4;
      6: return 7;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input int s);
    case (s)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      6, 7: return "R8";
      8: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [15:0] dut_vec();
    return {pc_wr_en, pc_wr_cond, addr_sel_data, mem_rd, mem_wr, ir_load,
            dst_sel_rd, wb_sel_mem, rf_wr, alu_a_sel, alu_b_sel, alu_mode, pc_next_sel};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cycles);
    end
  endtask

  function automatic logic [5:0] pick_op();
    case ($urandom % 7)
      0: return 6'b100011;
      1: return 6'b101011;
      2: return 6'b000000;
      3: return 6'b000100;
      4: return 6'b000010;
      5: return 6'b111111;
      default: return 6'($urandom);
    endcase
  endfunction

  always @(posedge clk) cycles++;

  initial begin
    wait (cycles > 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int exp_s;
    int prev_s;
    logic [5:0] prev_op;
    logic [15:0] held;
    void'($urandom(32'h5EED_0331));
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state, outputs while reset is held
    check("R1", {12'b0, step_code}, 16'd0);
    check("R1", dut_vec(), model_vec(0));
    exp_s = 0;
    prev_s = 0;
    prev_op = 6'd0;
    // directed: unknown opcode in decode, R11
    rst = 1'b0;
    opcode = 6'b111111;
    @(posedge clk); #1; exp_s = 1;
    @(negedge clk);
    check("R3", {12'b0, step_code}, 16'(exp_s));
    @(posedge clk); #1; exp_s = 0;
    @(negedge clk);
    check("R11", {12'b0, step_code}, 16'd0);
    check("R11", dut_vec(), model_vec(0));
    for (int k = 0; k < 4000; k++) begin
      // drive inputs at the falling edge
      rst = (($urandom % 250) == 0);
      if (exp_s == 0 || ($urandom % 5) == 0) opcode = pick_op();
      prev_s = exp_s;
      prev_op = opcode;
      @(posedge clk); #1;
      exp_s = rst ? 0 : model_next(prev_s, prev_op);
      @(negedge clk);
      if (rst) begin
        check("R1", {12'b0, step_code}, 16'd0);
      end else if (prev_s == 1 && model_next(1, prev_op) == 0) begin
        check("R11", {12'b0, step_code}, 16'd0);
      end else begin
        check(tag_of(exp_s), {12'b0, step_code}, 16'(exp_s));
      end
      check(tag_of(exp_s), dut_vec(), model_vec(exp_s));
      check("R12", {14'b0, mem_rd & mem_wr, rf_wr & mem_wr}, 16'd0);
      if (exp_s == 3 || exp_s == 1) begin
        held = dut_vec();
        opcode = ~opcode;
        #2;
        check("R13", dut_vec(), held);
        opcode = ~opcode;
      end
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule